// File: doc/BRIEF.md
# Dual-Issue Hazard Stall Calculator

This block sits beside the issue stage of a two-wide in-order core. For each pair of instructions fetched together, it compares the operands of the earlier instruction (the producer) with those of the later one (the consumer). The block detects three kinds of dependency:

- read-after-write (flow),
- write-after-write (output),
- write-after-read (anti).

It computes a stall length for each kind that applies. Class-specific adjustments are applied to that length, and the block reports the largest result as a cycle count.

Instruction classes arrive already decoded as a 4-bit code. Register operands arrive as 7-bit fields: a valid bit, a file bit (1 for floating point, 0 for integer) and a 5-bit index. The producer supplies a base latency and a write-back latency for each destination.

When a pair is offered and no stall is running, the computed count is loaded into a down-counter. The stall output stays high while the counter is nonzero, which holds issue of the second instruction.

The class codes are:

- 0: integer operation
- 1: load
- 2: floating-point register store
- 3: integer store
- 4: dynamic shift
- 5: single-precision floating-point operation
- 6: divide or square root
- 7: double-precision add, subtract or multiply
- 8: other double-precision operation
- 9: inner product
- 10: vector transform

Codes 5 to 10 form the floating-point execution group. Codes 1 to 3 form the load/store group.

Top module: `hz_stall_top`

## Requirements
- R1: Two operands match only when both valid bits are 1, the file bits are equal and the 5-bit indices are equal.
- R2: A consumer source that matches a producer destination gives a flow stall equal to the producer's base latency.
- R3: When the producer is in the floating-point execution group (codes 5 to 10) and the consumer is a floating-point register store (code 2), the flow latency is one less.
- R4: When a load (code 1) writes the register in the consumer's source slot 0 and the consumer is a dynamic shift (code 4), the flow latency is one more. A match in any other slot gets no such increase.
- R5: When a flow match falls on a floating-point destination of a producer whose base latency is below 2, and the consumer has code 7, 8, 9 or 10, the flow latency is raised to 2.
- R6: An output dependency is flagged only when the producer has a code from 5 to 10 and the consumer has a code from 1 to 3, and they share a destination. Its stall is the largest write-back latency among the producer's valid destinations, less 1 when the producer is code 6 and less 2 otherwise.
- R7: A consumer destination that matches a producer source stalls for 5 cycles when the producer is code 10, for 2 cycles when it is code 7, and for 0 cycles otherwise.
- R8: The reported count is the maximum of the flow, output and anti stalls, and any negative result is reported as 0.
- R9: A pair is accepted at a clock edge where pairValid is high and no stall is running. Stall then stays high for exactly the accepted count of cycles. A pair offered while the stall is running is not accepted until the cycle after the counter reaches zero.
- R10: While the synchronous reset is high, the counter is cleared and stall is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pairValid | input | 1 | An instruction pair is offered |
| firstClass | input | 4 | Class code of the earlier instruction |
| secondClass | input | 4 | Class code of the later instruction |
| firstSrc | input | 14 | Two source operands of the earlier instruction, slot 0 in the low 7 bits |
| firstDst | input | 14 | Two destination operands of the earlier instruction |
| secondSrc | input | 14 | Two source operands of the later instruction, slot 0 is the shift amount |
| secondDst | input | 14 | Two destination operands of the later instruction |
| firstLat | input | 4 | Base latency of the earlier instruction |
| firstDstLat | input | 8 | Write-back latency for each destination of the earlier instruction |
| stallCount | output | 5 | Stall count computed for the pair now on the inputs |
| stall | output | 1 | Issue of the second instruction is held |

## Verification
The cycle in which a running stall ends can coincide with the arrival of the next pair. To provoke this, the bench keeps pairValid high across a stall while it swaps in a new pair. It then judges that the first stall lasts its full length, that stall drops for exactly one cycle, and that the second pair's own count follows. A second coincidence comes from pairs where flow and anti dependencies both apply. There the bench checks that the larger of the two penalties wins, in both orderings.

// File: rtl/hz_pkg.sv
package hz_pkg;

  localparam int REG_IDX_W = 5;
  localparam int REG_OP_W  = REG_IDX_W + 2;
  localparam int CLASS_W   = 4;

  typedef enum logic [CLASS_W-1:0] {
    CLS_INT        = 4'd0,
    CLS_LOAD       = 4'd1,
    CLS_FSTORE     = 4'd2,
    CLS_ISTORE     = 4'd3,
    CLS_DSHIFT     = 4'd4,
    CLS_FSGL       = 4'd5,
    CLS_FDIV       = 4'd6,
    CLS_FDBL_ARITH = 4'd7,
    CLS_FDBL_OTHER = 4'd8,
    CLS_FIPR       = 4'd9,
    CLS_FTRV       = 4'd10
  } opClass_e;

  typedef struct packed {
    logic                 valid;
    logic                 isFp;
    logic [REG_IDX_W-1:0] idx;
  } regOp_t;

  typedef struct packed {
    logic load;
    logic dec;
  } ctrlStrb_t;

  function automatic logic isFeGroup(input logic [CLASS_W-1:0] c);
    return (c >= CLS_FSGL) && (c <= CLS_FTRV);
  endfunction

  function automatic logic isLsGroup(input logic [CLASS_W-1:0] c);
    return (c >= CLS_LOAD) && (c <= CLS_ISTORE);
  endfunction

  function automatic logic isDblConsumer(input logic [CLASS_W-1:0] c);
    return (c >= CLS_FDBL_ARITH) && (c <= CLS_FTRV);
  endfunction

endpackage

// File: rtl/hz_match.sv
module hz_match
  import hz_pkg::*;
#(
  parameter int NUM_A = 2,
  parameter int NUM_B = 2
) (
  input  regOp_t                       opsA [NUM_A],
  input  regOp_t                       opsB [NUM_B],
  output logic [NUM_A-1:0][NUM_B-1:0]  hit
);

  for (genvar ia = 0; ia < NUM_A; ia++) begin : gRowA
    for (genvar ib = 0; ib < NUM_B; ib++) begin : gColB
      assign hit[ia][ib] = opsA[ia].valid && opsB[ib].valid &&
                           (opsA[ia].isFp == opsB[ib].isFp) &&
                           (opsA[ia].idx == opsB[ib].idx);
    end
  end

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
(
  input  logic      pairValid,
  input  logic      cntZero,
  output ctrlStrb_t strb
);

  always_comb begin
    strb.load = pairValid && cntZero;
    strb.dec  = !cntZero;
  end

endmodule

// File: rtl/hz_datapath.sv
module hz_datapath
  import hz_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int NUM_DST = 2,
  parameter int LAT_W   = 4,
  parameter int CNT_W   = LAT_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrb_t            strb,
  input  logic [CLASS_W-1:0]   fClass,
  input  logic [CLASS_W-1:0]   sClass,
  input  regOp_t               fSrc [NUM_SRC],
  input  regOp_t               fDst [NUM_DST],
  input  regOp_t               sSrc [NUM_SRC],
  input  regOp_t               sDst [NUM_DST],
  input  logic [LAT_W-1:0]     fLat,
  input  logic [LAT_W-1:0]     fDstLat [NUM_DST],
  output logic [CNT_W-1:0]     calcCount,
  output logic [CNT_W-1:0]     remain,
  output logic                 cntZero
);

  localparam int SW = LAT_W + 3;
  localparam logic signed [SW-1:0] WAR_TRV_PEN = SW'(5);
  localparam logic signed [SW-1:0] WAR_DBL_PEN = SW'(2);
  localparam logic signed [SW-1:0] MIN_FP_LAT  = SW'(2);

  logic [NUM_SRC-1:0][NUM_DST-1:0] flowHit;
  logic [NUM_DST-1:0][NUM_DST-1:0] wawHit;
  logic [NUM_DST-1:0][NUM_SRC-1:0] warHit;

  hz_match #(.NUM_A(NUM_SRC), .NUM_B(NUM_DST)) uFlow (
    .opsA(sSrc), .opsB(fDst), .hit(flowHit)
  );
  hz_match #(.NUM_A(NUM_DST), .NUM_B(NUM_DST)) uOut (
    .opsA(sDst), .opsB(fDst), .hit(wawHit)
  );
  hz_match #(.NUM_A(NUM_DST), .NUM_B(NUM_SRC)) uAnti (
    .opsA(sDst), .opsB(fSrc), .hit(warHit)
  );

  logic                 flowAny, fpFlowAny, shiftHit, wawAny, warAny;
  logic [LAT_W-1:0]     maxDstLat;
  logic signed [SW-1:0] baseLat, flowStall, wawStall, warStall, best;

  always_comb begin
    flowAny   = |flowHit;
    wawAny    = |wawHit;
    warAny    = |warHit;
    shiftHit  = |flowHit[0];
    fpFlowAny = 1'b0;
    for (int si = 0; si < NUM_SRC; si++) begin
      for (int dj = 0; dj < NUM_DST; dj++) begin
        if (flowHit[si][dj] && fDst[dj].isFp) fpFlowAny = 1'b1;
      end
    end
    maxDstLat = '0;
    for (int dj = 0; dj < NUM_DST; dj++) begin
      if (fDst[dj].valid && (fDstLat[dj] > maxDstLat)) maxDstLat = fDstLat[dj];
    end
  end

  // flow (read-after-write) path with class-pair adjustments
  always_comb begin
    baseLat = signed'({{(SW-LAT_W){1'b0}}, fLat});
    if (fpFlowAny && (baseLat < MIN_FP_LAT) && isDblConsumer(sClass))
      baseLat = MIN_FP_LAT;
    if (isFeGroup(fClass) && (sClass == CLS_FSTORE))
      baseLat = baseLat - SW'(1);
    if ((fClass == CLS_LOAD) && (sClass == CLS_DSHIFT) && shiftHit)
      baseLat = baseLat + SW'(1);
    flowStall = flowAny ? baseLat : '0;
  end

  // output (write-after-write) path
  always_comb begin
    wawStall = '0;
    if (wawAny && isFeGroup(fClass) && isLsGroup(sClass)) begin
      if (fClass == CLS_FDIV)
        wawStall = signed'({{(SW-LAT_W){1'b0}}, maxDstLat}) - SW'(1);
      else
        wawStall = signed'({{(SW-LAT_W){1'b0}}, maxDstLat}) - SW'(2);
    end
  end

  // anti (write-after-read) path: fixed penalties
  always_comb begin
    warStall = '0;
    if (warAny) begin
      if (fClass == CLS_FTRV)            warStall = WAR_TRV_PEN;
      else if (fClass == CLS_FDBL_ARITH) warStall = WAR_DBL_PEN;
    end
  end

  always_comb begin
    best = flowStall;
    if (wawStall > best) best = wawStall;
    if (warStall > best) best = warStall;
    if (best < 0) best = '0;
    calcCount = best[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)            remain <= '0;
    else if (strb.load) remain <= calcCount;
    else if (strb.dec)  remain <= remain - CNT_W'(1);
  end

  assign cntZero = (remain == '0);

endmodule

// File: rtl/hz_stall_top.sv
module hz_stall_top
  import hz_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int NUM_DST = 2,
  parameter int LAT_W   = 4,
  parameter int CNT_W   = LAT_W + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pairValid,
  input  logic [CLASS_W-1:0]            firstClass,
  input  logic [CLASS_W-1:0]            secondClass,
  input  logic [NUM_SRC*REG_OP_W-1:0]   firstSrc,
  input  logic [NUM_DST*REG_OP_W-1:0]   firstDst,
  input  logic [NUM_SRC*REG_OP_W-1:0]   secondSrc,
  input  logic [NUM_DST*REG_OP_W-1:0]   secondDst,
  input  logic [LAT_W-1:0]              firstLat,
  input  logic [NUM_DST*LAT_W-1:0]      firstDstLat,
  output logic [CNT_W-1:0]              stallCount,
  output logic                          stall
);

  regOp_t           fSrcA [NUM_SRC];
  regOp_t           sSrcA [NUM_SRC];
  regOp_t           fDstA [NUM_DST];
  regOp_t           sDstA [NUM_DST];
  logic [LAT_W-1:0] dstLatA [NUM_DST];

  for (genvar gs = 0; gs < NUM_SRC; gs++) begin : gSrcUnpack
    assign fSrcA[gs] = firstSrc[gs*REG_OP_W +: REG_OP_W];
    assign sSrcA[gs] = secondSrc[gs*REG_OP_W +: REG_OP_W];
  end
  for (genvar gd = 0; gd < NUM_DST; gd++) begin : gDstUnpack
    assign fDstA[gd]   = firstDst[gd*REG_OP_W +: REG_OP_W];
    assign sDstA[gd]   = secondDst[gd*REG_OP_W +: REG_OP_W];
    assign dstLatA[gd] = firstDstLat[gd*LAT_W +: LAT_W];
  end

  ctrlStrb_t        strb;
  logic             cntZero;
  logic [CNT_W-1:0] remain;

  hz_ctrl uCtrl (
    .pairValid(pairValid),
    .cntZero  (cntZero),
    .strb     (strb)
  );

  hz_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .LAT_W(LAT_W), .CNT_W(CNT_W)
  ) uData (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .fClass   (firstClass),
    .sClass   (secondClass),
    .fSrc     (fSrcA),
    .fDst     (fDstA),
    .sSrc     (sSrcA),
    .sDst     (sDstA),
    .fLat     (firstLat),
    .fDstLat  (dstLatA),
    .calcCount(stallCount),
    .remain   (remain),
    .cntZero  (cntZero)
  );

  assign stall = !cntZero;

endmodule

// File: rtl/hz_stall_chk.sv
module hz_stall_chk #(
  parameter int LAT_W = 4,
  parameter int CNT_W = LAT_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             pairValid,
  input logic             stall,
  input logic [CNT_W-1:0] stallCount,
  input logic [CNT_W-1:0] remain
);

  localparam int LIM = ((1 << LAT_W) > 5) ? (1 << LAT_W) : 5;

  // R9: an accepted pair loads its computed count
  assert_load_R9: assert property (@(posedge clk) disable iff (rst)
    (pairValid && !stall) |=> (remain == $past(stallCount)));

  // R9: a running stall counts down by one each cycle
  assert_countdown_R9: assert property (@(posedge clk) disable iff (rst)
    stall |=> (remain == $past(remain) - CNT_W'(1)));

  // R9: a zero count never raises stall
  assert_zero_no_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (pairValid && !stall && (stallCount == '0)) |=> !stall);

  // R10: the cycle after reset has stall low
  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !stall);

  // R8: computed count stays within the largest reachable penalty
  assert_bound_R8: assert property (@(posedge clk) disable iff (rst)
    (int'(stallCount) <= LIM));

endmodule

bind hz_stall_top hz_stall_chk #(.LAT_W(LAT_W), .CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .pairValid (pairValid),
  .stall     (stall),
  .stallCount(stallCount),
  .remain    (remain)
);

// File: tb/tb_hz_stall_top.sv
module tb_hz_stall_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pairValid = 1'b0;
  logic [3:0]  firstClass = '0, secondClass = '0;
  logic [13:0] firstSrc = '0, firstDst = '0, secondSrc = '0, secondDst = '0;
  logic [3:0]  firstLat = '0;
  logic [7:0]  firstDstLat = '0;
  logic [4:0]  stallCount;
  logic        stall;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  hz_stall_top dut (
    .clk(clk), .rst(rst), .pairValid(pairValid),
    .firstClass(firstClass), .secondClass(secondClass),
    .firstSrc(firstSrc), .firstDst(firstDst),
    .secondSrc(secondSrc), .secondDst(secondDst),
    .firstLat(firstLat), .firstDstLat(firstDstLat),
    .stallCount(stallCount), .stall(stall)
  );

  function automatic logic [6:0] op(input bit fp, input int idx);
    return {1'b1, fp, idx[4:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearOps();
    firstClass = '0; secondClass = '0;
    firstSrc = '0; firstDst = '0; secondSrc = '0; secondDst = '0;
    firstLat = '0; firstDstLat = '0;
  endtask

  task automatic runPair(input string req, input int exp);
    int n;
    @(negedge clk);
    pairValid = 1'b1;
    #1;
    check(int'(stallCount) == exp, {req, " count"}, int'(stallCount), exp);
    @(negedge clk);
    pairValid = 1'b0;
    n = 0;
    while (stall && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == exp, {req, " duration"}, n, exp);
  endtask

  task automatic testReset();
    clearOps();
    @(negedge clk);
    check(stall == 1'b0, "R10 reset stall", int'(stall), 0);
    check(stallCount == 5'd0, "R1 no operands", int'(stallCount), 0);
  endtask

  task automatic testFlow();
    clearOps(); firstClass = 4'd0; secondClass = 4'd0; firstLat = 4'd1;
    firstDst[6:0] = op(0, 3); secondSrc[13:7] = op(0, 3);
    runPair("R2 int flow", 1);
    clearOps(); firstClass = 4'd5; secondClass = 4'd5; firstLat = 4'd4;
    firstDst[13:7] = op(1, 2); secondSrc[6:0] = op(1, 2);
    runPair("R2 fp flow", 4);
  endtask

  task automatic testMatch();
    clearOps(); firstClass = 4'd0; secondClass = 4'd0; firstLat = 4'd3;
    firstDst[6:0] = op(0, 3); secondSrc[6:0] = op(1, 3);
    runPair("R1 file mismatch", 0);
    secondSrc[6:0] = {1'b0, 1'b0, 5'd3};
    runPair("R1 invalid operand", 0);
    secondSrc[6:0] = op(0, 4);
    runPair("R1 index mismatch", 0);
  endtask

  task automatic testStoreAdj();
    clearOps(); firstClass = 4'd5; secondClass = 4'd2; firstLat = 4'd4;
    firstDst[6:0] = op(1, 5); secondSrc[13:7] = op(1, 5);
    runPair("R3 fp store", 3);
  endtask

  task automatic testShiftAdj();
    clearOps(); firstClass = 4'd1; secondClass = 4'd4; firstLat = 4'd2;
    firstDst[6:0] = op(0, 4); secondSrc[6:0] = op(0, 4);
    runPair("R4 shift amount", 3);
    secondSrc = '0; secondSrc[13:7] = op(0, 4);
    runPair("R4 other slot", 2);
  endtask

  task automatic testRaise();
    clearOps(); firstClass = 4'd1; secondClass = 4'd9; firstLat = 4'd1;
    firstDst[6:0] = op(1, 6); secondSrc[6:0] = op(1, 6);
    runPair("R5 inner product", 2);
    secondClass = 4'd8;
    runPair("R5 double op", 2);
    secondClass = 4'd0;
    runPair("R5 integer consumer", 1);
  endtask

  task automatic testOutput();
    clearOps(); firstClass = 4'd5; secondClass = 4'd1; firstLat = 4'd3;
    firstDst[6:0] = op(1, 1); firstDst[13:7] = op(1, 2);
    firstDstLat = {4'd6, 4'd3};
    secondDst[6:0] = op(1, 2);
    runPair("R6 max write-back", 4);
    firstClass = 4'd6; firstDstLat = {4'd10, 4'd3};
    runPair("R6 divide", 9);
    secondClass = 4'd0;
    runPair("R6 non load-store", 0);
    firstClass = 4'd5; secondClass = 4'd3; firstDstLat = {4'd1, 4'd1};
    runPair("R8 negative clamp", 0);
  endtask

  task automatic testAnti();
    clearOps(); firstClass = 4'd10; secondClass = 4'd1; firstLat = 4'd7;
    firstSrc[6:0] = op(1, 8); firstDst[6:0] = op(1, 12); firstDstLat = 8'h07;
    secondDst[6:0] = op(1, 8);
    runPair("R7 vector transform", 5);
    firstClass = 4'd7; secondClass = 4'd0;
    runPair("R7 double arith", 2);
    firstClass = 4'd5;
    runPair("R7 other producer", 0);
  endtask

  task automatic testMax();
    clearOps(); firstClass = 4'd10; secondClass = 4'd5; firstLat = 4'd7;
    firstSrc[6:0] = op(1, 8); firstDst[6:0] = op(1, 9);
    secondSrc[6:0] = op(1, 9); secondDst[6:0] = op(1, 8);
    runPair("R8 flow wins", 7);
    firstLat = 4'd3;
    runPair("R8 anti wins", 5);
  endtask

  task automatic testHold();
    int n;
    clearOps(); firstClass = 4'd0; secondClass = 4'd0; firstLat = 4'd3;
    firstDst[6:0] = op(0, 1); secondSrc[6:0] = op(0, 1);
    @(negedge clk);
    pairValid = 1'b1;
    @(negedge clk);
    firstLat = 4'd7;
    n = 0;
    while (stall && n < 100) begin n++; @(negedge clk); end
    check(n == 3, "R9 first stall held", n, 3);
    check(stall == 1'b0, "R9 one idle cycle", int'(stall), 0);
    @(negedge clk);
    pairValid = 1'b0;
    n = 0;
    while (stall && n < 100) begin n++; @(negedge clk); end
    check(n == 7, "R9 next pair", n, 7);
  endtask

  task automatic testResetMid();
    clearOps(); firstClass = 4'd0; firstLat = 4'd7;
    firstDst[6:0] = op(0, 2); secondSrc[6:0] = op(0, 2);
    @(negedge clk);
    pairValid = 1'b1;
    @(negedge clk);
    pairValid = 1'b0;
    @(negedge clk);
    check(stall == 1'b1, "R10 stall running", int'(stall), 1);
    rst = 1'b1;
    @(negedge clk);
    check(stall == 1'b0, "R10 reset clears", int'(stall), 0);
    rst = 1'b0;
    @(negedge clk);
    check(stall == 1'b0, "R10 stays idle", int'(stall), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testFlow();
    testMatch();
    testStoreAdj();
    testShiftAdj();
    testRaise();
    testOutput();
    testAnti();
    testMax();
    testHold();
    testResetMid();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule